// File: doc/BRIEF.md
# Audio Master Clock Divider

This block derives an audio master clock and a once-per-frame strobe from an oversampled reference. The reference belongs to one of two families, 512 or 384 times the sample rate, chosen by a base-select bit. A 3-bit ratio code then divides that reference by a power of two. With the 512 family this gives master clocks from 512 fs down to 32 fs. With the 384 family it gives 384 fs down to 48 fs. Supported sample rates span 8 kHz to 192 kHz; the reference itself comes from an external PLL.

Every output is a register in one synchronous domain, so the block runs on a clock at twice the reference rate. Code 0 then toggles the master clock on every edge and still yields a clean 50% duty cycle. A single free-running phase counter spans one frame, which is 1024 edges for the 512 family and 768 edges for the 384 family. The master clock is one counter bit chosen by the ratio code.

Configuration requested while the block is running is held back until the counter wraps. This prevents runt pulses. While stopped, the block takes a new configuration on the next edge. An illegal pairing of code and base raises an error output and keeps the master clock low. All controls are plain level inputs; there is no data stream.

Top module: `amclk_div`

## Requirements
- R1: While rst_n is low, mclk, frame_stb and cfg_err are all 0.
- R2: While running with a legal configuration, mclk after the n-th rising edge since run was sampled high equals bit `code` of the frame phase. The phase counts 1, 2, … and wraps to 0 at the frame length. The output therefore has a period of 2^(code+1) clock edges (2^code reference cycles) and is high for exactly half of every frame.
- R3: With base_sel = 0 (512 fs family), codes 0 to 4 are legal and give 512, 256, 128, 64 and 32 fs. One frame is 1024 clock edges.
- R4: With base_sel = 1 (384 fs family), codes 0 to 3 are legal and give 384, 192, 96 and 48 fs. One frame is 768 clock edges.
- R5: On the edge after run is sampled low, mclk and frame_stb are 0 and the phase returns to 0. When run rises again, the first edge gives phase 1.
- R6: A configuration is illegal when the code is 4 with base_sel = 1, or when the code is 5, 6 or 7 with either base. An illegal configuration drives cfg_err to 1 and holds mclk at 0.
- R7: frame_stb is high for exactly one cycle per frame: the cycle after the edge on which the phase wraps to 0. It is never high while stopped.
- R8: A change to base_sel or mult_code while running takes effect only at the wrap edge. Until then, mclk, the frame length and cfg_err follow the previous configuration.
- R9: While run is low, the configuration on base_sel and mult_code is adopted on every edge, so cfg_err reflects it one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref2x | input | 1 | Clock at twice the oversampled reference (1024 fs or 768 fs) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the phase counter and the master clock output |
| base_sel | input | 1 | Reference family: 0 = 512 fs, 1 = 384 fs |
| mult_code | input | 3 | Ratio code; master clock = reference / 2^code |
| mclk | output | 1 | Master clock output, 50% duty |
| frame_stb | output | 1 | One-cycle pulse once per frame |
| cfg_err | output | 1 | High while the adopted configuration is illegal |

## Verification
The hardest case to reach is a configuration change landing mid-frame while running. The output must keep the old ratio until the wrap edge and only then switch, including a switch between families that alters the frame length itself. The stimulus starts a run, changes the ratio code a few hundred edges into the frame, and later changes both base and code mid-frame. A cycle-exact phase model in the bench adopts the request only at its own computed wrap and predicts every output sample. Every legal and illegal code is also swept under both bases across a full frame, with the high-cycle and strobe counts checked arithmetically.

// File: rtl/amclk_pkg.sv
package amclk_pkg;
  localparam int CODE_W = 3;

  typedef enum logic {
    BASE_512 = 1'b0,
    BASE_384 = 1'b1
  } base_e;

  typedef struct packed {
    base_e             base;
    logic [CODE_W-1:0] code;
  } amclk_cfg_t;

  // legal when the code does not exceed the family's largest divide
  function automatic logic cfg_legal(amclk_cfg_t c, int max_a, int max_b);
    if (c.base == BASE_512) return (int'(c.code) <= max_a);
    else                    return (int'(c.code) <= max_b);
  endfunction
endpackage

// File: rtl/amclk_cfg_hold.sv
module amclk_cfg_hold
  import amclk_pkg::*;
#(
  parameter int MAX_A = 4,
  parameter int MAX_B = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       wrap,
  input  amclk_cfg_t req_cfg,
  output amclk_cfg_t act_cfg,
  output amclk_cfg_t nxt_cfg,
  output logic       nxt_legal
);
  amclk_cfg_t act_q;

  // adopt the request when stopped or at the frame boundary
  always_comb begin
    if (!run || wrap) nxt_cfg = req_cfg;
    else              nxt_cfg = act_q;
    nxt_legal = cfg_legal(nxt_cfg, MAX_A, MAX_B);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= nxt_cfg;
  end

  assign act_cfg = act_q;
endmodule

// File: rtl/amclk_phase_ctr.sv
module amclk_phase_ctr
  import amclk_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int LAST_A = 1023,
  parameter int LAST_B = 767
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  base_e            act_base,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_v;

  always_comb begin
    last_v = (act_base == BASE_512) ? CNT_W'(LAST_A) : CNT_W'(LAST_B);
    wrap   = run && (cnt_q == last_v);
    if (!run)      nxt_cnt = '0;
    else if (wrap) nxt_cnt = '0;
    else           nxt_cnt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_cnt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/amclk_out_stage.sv
module amclk_out_stage
  import amclk_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  nxt_cnt,
  input  logic [CODE_W-1:0] nxt_code,
  input  logic              nxt_legal,
  output logic              mclk,
  output logic              frame_stb,
  output logic              cfg_err
);
  localparam int NTAP = 1 << CODE_W;

  logic [NTAP-1:0] taps;

  // one tap per code; codes past the counter width read as zero
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    if (i < CNT_W) begin : g_real
      assign taps[i] = nxt_cnt[i];
    end else begin : g_none
      assign taps[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk      <= 1'b0;
      frame_stb <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      mclk      <= run && nxt_legal && taps[nxt_code];
      frame_stb <= wrap;
      cfg_err   <= !nxt_legal;
    end
  end
endmodule

// File: rtl/amclk_div.sv
module amclk_div
  import amclk_pkg::*;
#(
  parameter int REF_A = 512,
  parameter int REF_B = 384,
  parameter int MAX_A = 4,
  parameter int MAX_B = 3
) (
  input  logic              clk_ref2x,
  input  logic              rst_n,
  input  logic              run,
  input  logic              base_sel,
  input  logic [CODE_W-1:0] mult_code,
  output logic              mclk,
  output logic              frame_stb,
  output logic              cfg_err
);
  localparam int LAST_A = 2 * REF_A - 1;
  localparam int LAST_B = 2 * REF_B - 1;
  localparam int CNT_W  = $clog2(2 * REF_A);

  amclk_cfg_t       req_cfg, act_cfg, nxt_cfg;
  logic             nxt_legal;
  logic             wrap;
  logic [CNT_W-1:0] cnt, nxt_cnt;

  assign req_cfg.base = base_e'(base_sel);
  assign req_cfg.code = mult_code;

  amclk_cfg_hold #(.MAX_A(MAX_A), .MAX_B(MAX_B)) u_cfg (
    .clk(clk_ref2x), .rst_n(rst_n), .run(run), .wrap(wrap),
    .req_cfg(req_cfg), .act_cfg(act_cfg), .nxt_cfg(nxt_cfg),
    .nxt_legal(nxt_legal)
  );

  amclk_phase_ctr #(.CNT_W(CNT_W), .LAST_A(LAST_A), .LAST_B(LAST_B)) u_ctr (
    .clk(clk_ref2x), .rst_n(rst_n), .run(run), .act_base(act_cfg.base),
    .cnt(cnt), .nxt_cnt(nxt_cnt), .wrap(wrap)
  );

  amclk_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk(clk_ref2x), .rst_n(rst_n), .run(run), .wrap(wrap),
    .nxt_cnt(nxt_cnt), .nxt_code(nxt_cfg.code), .nxt_legal(nxt_legal),
    .mclk(mclk), .frame_stb(frame_stb), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/amclk_div_chk.sv
module amclk_div_chk
  import amclk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       mclk,
  input logic       frame_stb,
  input logic       cfg_err,
  input logic       wrap,
  input amclk_cfg_t act_cfg
);
  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!mclk && !frame_stb && !cfg_err)
        else $error("R1 outputs active in reset");
    end
  end

  // R5: a stopped block is silent on the next edge
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!mclk && !frame_stb));

  // R6: an illegal configuration never lets the clock out
  p_err_mutes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !mclk);

  // R7: strobe lasts a single cycle
  p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);

  // R8: adopted configuration frozen between wraps while running
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(act_cfg));
endmodule

bind amclk_div amclk_div_chk u_chk (
  .clk(clk_ref2x), .rst_n(rst_n), .run(run), .mclk(mclk),
  .frame_stb(frame_stb), .cfg_err(cfg_err), .wrap(wrap), .act_cfg(act_cfg)
);

// File: tb/sim_amclk_div.sv
`timescale 1ns/1ps
module sim_amclk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       base_sel = 1'b0;
  logic [2:0] mult_code = 3'd0;
  logic       mclk, frame_stb, cfg_err;

  int checks = 0;
  int failures = 0;

  // model state
  int   m_p = 0;
  bit   m_base = 0;
  int   m_code = 0;
  bit   e_mclk, e_stb, e_err;
  // segment bookkeeping
  int   seg_bad = 0;
  bit [2:0] seg_got, seg_exp;
  int   hi_cnt = 0;
  int   stb_cnt = 0;

  always #4 clk = ~clk;

  amclk_div u0 (
    .clk_ref2x(clk), .rst_n(rst_n), .run(run), .base_sel(base_sel),
    .mult_code(mult_code), .mclk(mclk), .frame_stb(frame_stb), .cfg_err(cfg_err)
  );

  function automatic int frame_len(bit b);
    return b ? 768 : 1024;
  endfunction

  function automatic bit legal_of(bit b, int c);
    return b ? (c <= 3) : (c <= 4);
  endfunction

  task automatic check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic seg_start();
    seg_bad = 0; hi_cnt = 0; stb_cnt = 0;
  endtask

  task automatic seg_end(string tag);
    checks++;
    if (seg_bad != 0) begin
      failures++;
      $display("FAIL %s per-cycle mismatch count=%0d got={mclk,stb,err}=%b expected=%b",
               tag, seg_bad, seg_got, seg_exp);
    end
  endtask

  // one clock edge: update the requirement model, then compare at negedge
  task automatic tick();
    @(posedge clk);
    if (!run) begin
      m_p = 0; m_base = base_sel; m_code = int'(mult_code); e_stb = 0;
    end else if (m_p == frame_len(m_base) - 1) begin
      m_p = 0; m_base = base_sel; m_code = int'(mult_code); e_stb = 1;
    end else begin
      m_p++; e_stb = 0;
    end
    e_err  = !legal_of(m_base, m_code);
    e_mclk = run && !e_err && (((m_p >> m_code) & 1) == 1);
    @(negedge clk);
    if ({mclk, frame_stb, cfg_err} !== {e_mclk, e_stb, e_err}) begin
      if (seg_bad == 0) begin
        seg_got = {mclk, frame_stb, cfg_err};
        seg_exp = {e_mclk, e_stb, e_err};
      end
      seg_bad++;
    end
    if (mclk) hi_cnt++;
    if (frame_stb) stb_cnt++;
  endtask

  initial begin
    #1_600_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3;
    // R1: reset state
    check(mclk == 0 && frame_stb == 0 && cfg_err == 0, "R1 reset outputs",
          {mclk, frame_stb, cfg_err}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every code under both families
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 8; c++) begin
        string tag;
        int f;
        bit lg;
        f  = frame_len(b[0]);
        lg = legal_of(b[0], c);
        tag = lg ? (b == 0 ? "R3" : "R4") : "R6";
        run = 1'b0; base_sel = b[0]; mult_code = c[2:0];
        seg_start();
        tick(); tick();
        seg_end("R9 idle adoption");
        check(cfg_err == !lg, "R9 cfg_err while idle", cfg_err, !lg);
        run = 1'b1;
        seg_start();
        repeat (f) tick();
        check(hi_cnt == (lg ? f / 2 : 0), lg ? "R2 half-frame high count" : "R6 mclk muted",
              hi_cnt, lg ? f / 2 : 0);
        repeat (8) tick();
        seg_end(tag);
        check(stb_cnt == 1, "R7 one strobe per frame", stb_cnt, 1);
      end
    end

    // R5: stopping clears outputs, restart begins at phase 1
    run = 1'b0; base_sel = 1'b0; mult_code = 3'd0;
    tick();
    check(mclk == 0 && frame_stb == 0, "R5 stop clears outputs", mclk, 0);
    run = 1'b1;
    tick();
    check(mclk == 1, "R5 restart phase 1 code 0", mclk, 1);
    tick();
    check(mclk == 0, "R5 restart phase 2 code 0", mclk, 0);
    run = 1'b0;
    tick();
    check(mclk == 0, "R5 stop mid-frame", mclk, 0);

    // R8: mid-frame changes take effect only at the wrap
    base_sel = 1'b0; mult_code = 3'd1;
    tick();
    run = 1'b1;
    seg_start();
    repeat (300) tick();
    mult_code = 3'd3;
    repeat (900) tick();
    base_sel = 1'b1; mult_code = 3'd0;
    repeat (1500) tick();
    base_sel = 1'b1; mult_code = 3'd4;
    repeat (1000) tick();
    seg_end("R8 deferred reconfiguration");
    check(cfg_err == 1, "R8 illegal request adopted after wrap", cfg_err, 1);
    check(stb_cnt == 4, "R7 strobes across mixed frames", stb_cnt, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule